// File: doc/BRIEF.md
# Mode-Dependent Address/GPIO Port

This block controls one 8-bit parallel port. Each pin can act as a general-purpose input, a general-purpose output, or an external address output. A 3-bit operating-mode input and a per-bit direction register together pick the role of each pin. In some modes the low pins are forced to carry address bits whatever the direction register holds. The block drives an output value, an output enable and a pull-up request for every pin. It also applies open-drain signalling to general outputs.

Software reaches five byte-wide registers through a simple memory-mapped bus: direction, output data, pin readback, pull-up enable and open-drain enable. The direction register is write-only. A manual reset clears the other control registers but leaves the direction register as it was.

While the chip is in software standby, a hold flag chooses between two behaviours for address pins: they keep driving the last address seen, or they release to high impedance. A build parameter selects a variant without pull-up and open-drain control.

Top module: `gpio_addr_port`

## Requirements
- R1: While rst_n is low or hw_stby is high at a clock edge, the direction, data, pull-up and open-drain registers all clear to 0x00. In mode 7 this leaves every pin undriven with no pull-up request.
- R2: A clock edge with man_rst high (rst_n high, hw_stby low) clears the data, pull-up and open-drain registers and leaves the direction register unchanged. Bus writes in that cycle are dropped.
- R3: A read of the direction register at 0xFEB9 always returns 0x00. A write at that address sets the direction bits, where 1 selects drive.
- R4: In mode 7, a pin whose direction bit is 1 drives the matching data register bit (data register at 0xFF69, readable). A pin whose direction bit is 0 is an input with pin_oe low.
- R5: In mode 6, a pin whose direction bit is 1 drives the matching addr_in bit. Otherwise it is an input.
- R6: In modes 4 and 5, pins 4 to 0 always drive the matching addr_in bits. Pins 7 to 5 drive address when their direction bit is 1 and are inputs otherwise.
- R7: In modes 0 to 3, every pin is an input (pin_oe is 0x00).
- R8: While sw_stby and hold_en are both high, pins acting as address outputs keep driving the addr_in value captured on the last clock edge at which sw_stby was low.
- R9: While sw_stby is high and hold_en is low, pins acting as address outputs have pin_oe low. General outputs are not affected by standby.
- R10: pin_pu[i] is high only when pull-up bit i (register at 0xFF70, readable) is 1 and pin i is acting as an input.
- R11: When open-drain bit i (register at 0xFF77, readable) is 1 and pin i is a general output, pin i drives 0 when data bit i is 0 and is undriven when data bit i is 1.
- R12: A read at 0xFF59 returns pin_in as sampled two clock edges earlier, through a two-flop synchronizer that clears on rst_n.
- R13: With ROMLESS=1, the pull-up and open-drain registers read 0x00 and writes to them have no effect on any pin.
- R14: bus_rdata is 0x00 when bus_sel is low or the address matches no register. A write to an unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hw_stby | input | 1 | Hardware standby, clears control registers |
| man_rst | input | 1 | Manual reset, keeps direction register |
| mode | input | 3 | Operating mode |
| sw_stby | input | 1 | Software standby flag |
| hold_en | input | 1 | Keep address outputs driven during software standby |
| addr_in | input | 8 | Address bits routed to this port |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Low 16 bits of the access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up requests |

## Verification
The pin mux is exercised with a fixed direction pattern in each mode, in a high/low mixed arrangement. This shows whether the forced low pins in modes 4 and 5 are told apart from the direction-gated upper pins. Several addr_in values are applied in mode 6 and in modes 4 and 5, which separates address routing from data-register routing. Standby runs hold the address steady on the bus and then change it during standby, and they try both hold settings. This exposes whether a pin holds a captured value or follows the live bus. Readback uses a changing pin pattern on every cycle, so any synchronizer latency other than two edges shows up.

// File: rtl/gpio_addr_port_pkg.sv
// Shared types and mode codes for the address/GPIO port.
// Assumes mode encoding 4..7 as used by the pin mux.
package gpio_addr_port_pkg;

    typedef enum logic [1:0] {
        PIN_INPUT = 2'd0,
        PIN_GPO   = 2'd1,
        PIN_ADDR  = 2'd2
    } pin_fn_e;

    localparam logic [2:0] MODE_ADDR_LO_A = 3'd4;
    localparam logic [2:0] MODE_ADDR_LO_B = 3'd5;
    localparam logic [2:0] MODE_ADDR_SEL  = 3'd6;
    localparam logic [2:0] MODE_SINGLE    = 3'd7;

endpackage

// File: rtl/gpio_addr_port_regs.sv
// Control register file and bus decode for the port.
// Holds direction, data, pull-up and open-drain bytes; direction reads as zero.
// Assumes single-cycle bus writes and a combinational read path.
module gpio_addr_port_regs #(
    parameter int          W         = 8,
    parameter int          AW        = 16,
    parameter logic [15:0] ADDR_DIR  = 16'hFEB9,
    parameter logic [15:0] ADDR_DAT  = 16'hFF69,
    parameter logic [15:0] ADDR_PORT = 16'hFF59,
    parameter logic [15:0] ADDR_PU   = 16'hFF70,
    parameter logic [15:0] ADDR_OD   = 16'hFF77,
    parameter bit          ROMLESS   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_stby,
    input  logic          man_rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  port_sync,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  dat_q,
    output logic [W-1:0]  pu_q,
    output logic [W-1:0]  od_q
);
    localparam logic [AW-1:0] A_DIR  = AW'(ADDR_DIR);
    localparam logic [AW-1:0] A_DAT  = AW'(ADDR_DAT);
    localparam logic [AW-1:0] A_PORT = AW'(ADDR_PORT);
    localparam logic [AW-1:0] A_PU   = AW'(ADDR_PU);
    localparam logic [AW-1:0] A_OD   = AW'(ADDR_OD);

    logic wr_en;
    logic full_clr;

    assign wr_en    = bus_sel && bus_wr && !man_rst;
    assign full_clr = !rst_n || hw_stby;

    // Direction register: cleared by power-on and hardware standby only.
    always_ff @(posedge clk) begin
        if (full_clr)
            dir_q <= '0;
        else if (wr_en && bus_addr == A_DIR)
            dir_q <= bus_wdata;
    end

    // Data register: also cleared by manual reset.
    always_ff @(posedge clk) begin
        if (full_clr || man_rst)
            dat_q <= '0;
        else if (wr_en && bus_addr == A_DAT)
            dat_q <= bus_wdata;
    end

    generate
        if (ROMLESS) begin : g_no_pad_ctl
            assign pu_q = '0;
            assign od_q = '0;
        end else begin : g_pad_ctl
            // Pull-up and open-drain registers, cleared like the data register.
            always_ff @(posedge clk) begin
                if (full_clr || man_rst) begin
                    pu_q <= '0;
                    od_q <= '0;
                end else if (wr_en) begin
                    if (bus_addr == A_PU) pu_q <= bus_wdata;
                    if (bus_addr == A_OD) od_q <= bus_wdata;
                end
            end
        end
    endgenerate

    // Read mux: direction is write-only and reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_DAT:   bus_rdata = dat_q;
                A_PORT:  bus_rdata = port_sync;
                A_PU:    bus_rdata = pu_q;
                A_OD:    bus_rdata = od_q;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_addr_port_sync.sv
// Multi-stage synchronizer for the pin readback path.
// Assumes pins are asynchronous to clk; cleared by power-on reset only.
module gpio_addr_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= '0;
                else
                    chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_addr_port_mux.sv
// Per-pin function select and pad drive generation.
// Chooses input, general output or address output from mode and direction,
// then applies open-drain, pull-up and software-standby rules.
module gpio_addr_port_mux
    import gpio_addr_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int FORCED_PINS = 5
) (
    input  logic [2:0]   mode,
    input  logic         sw_stby,
    input  logic         hold_en,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] dat_q,
    input  logic [W-1:0] pu_q,
    input  logic [W-1:0] od_q,
    input  logic [W-1:0] addr_live,
    input  logic [W-1:0] addr_hold,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            localparam bit FORCED = (i < FORCED_PINS);
            pin_fn_e fn;
            logic    o, oe, pu;

            // Decode the role of this pin from mode and direction bit.
            always_comb begin
                case (mode)
                    MODE_SINGLE:    fn = dir_q[i] ? PIN_GPO  : PIN_INPUT;
                    MODE_ADDR_SEL:  fn = dir_q[i] ? PIN_ADDR : PIN_INPUT;
                    MODE_ADDR_LO_A,
                    MODE_ADDR_LO_B: fn = (FORCED || dir_q[i]) ? PIN_ADDR : PIN_INPUT;
                    default:        fn = PIN_INPUT;
                endcase
            end

            // Produce pad value, enable and pull-up request for the role.
            always_comb begin
                o  = 1'b0;
                oe = 1'b0;
                pu = 1'b0;
                case (fn)
                    PIN_GPO: begin
                        if (od_q[i]) begin
                            o  = 1'b0;
                            oe = !dat_q[i];
                        end else begin
                            o  = dat_q[i];
                            oe = 1'b1;
                        end
                    end
                    PIN_ADDR: begin
                        if (sw_stby && !hold_en) begin
                            o  = 1'b0;
                            oe = 1'b0;
                        end else begin
                            o  = sw_stby ? addr_hold[i] : addr_live[i];
                            oe = 1'b1;
                        end
                    end
                    default: pu = pu_q[i];
                endcase
            end

            assign pin_out[i] = o;
            assign pin_oe[i]  = oe;
            assign pin_pu[i]  = pu;
        end
    endgenerate

endmodule

// File: rtl/gpio_addr_port.sv
// Top of the mode-dependent address/GPIO port.
// Ties the register file, readback synchronizer, standby address hold and
// per-pin mux together. Assumes addr_in is synchronous to clk.
module gpio_addr_port #(
    parameter int          W           = 8,
    parameter int          AW          = 16,
    parameter int          FORCED_PINS = 5,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] ADDR_DIR    = 16'hFEB9,
    parameter logic [15:0] ADDR_DAT    = 16'hFF69,
    parameter logic [15:0] ADDR_PORT   = 16'hFF59,
    parameter logic [15:0] ADDR_PU     = 16'hFF70,
    parameter logic [15:0] ADDR_OD     = 16'hFF77,
    parameter bit          ROMLESS     = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_stby,
    input  logic          man_rst,
    input  logic [2:0]    mode,
    input  logic          sw_stby,
    input  logic          hold_en,
    input  logic [W-1:0]  addr_in,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_pu
);
    logic [W-1:0] dir_q, dat_q, pu_q, od_q;
    logic [W-1:0] port_sync;
    logic [W-1:0] addr_hold;

    // Capture the address while awake so standby can keep driving it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_hold <= '0;
        else if (!sw_stby)
            addr_hold <= addr_in;
    end

    gpio_addr_port_regs #(
        .W(W), .AW(AW),
        .ADDR_DIR(ADDR_DIR), .ADDR_DAT(ADDR_DAT), .ADDR_PORT(ADDR_PORT),
        .ADDR_PU(ADDR_PU), .ADDR_OD(ADDR_OD), .ROMLESS(ROMLESS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .man_rst(man_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .port_sync(port_sync), .bus_rdata(bus_rdata),
        .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q), .od_q(od_q)
    );

    gpio_addr_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(port_sync)
    );

    gpio_addr_port_mux #(.W(W), .FORCED_PINS(FORCED_PINS)) u_mux (
        .mode(mode), .sw_stby(sw_stby), .hold_en(hold_en),
        .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q), .od_q(od_q),
        .addr_live(addr_in), .addr_hold(addr_hold),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

endmodule

// File: rtl/gpio_addr_port_chk.sv
// Property checker for the address/GPIO port, bound to every instance.
module gpio_addr_port_chk #(
    parameter int          W           = 8,
    parameter int          AW          = 16,
    parameter int          FORCED_PINS = 5,
    parameter logic [15:0] ADDR_DIR    = 16'hFEB9,
    parameter logic [15:0] ADDR_PORT   = 16'hFF59
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode,
    input logic          sw_stby,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  pin_oe,
    input logic [W-1:0]  pin_pu
);
    localparam logic [W-1:0] FORCED_MASK = W'((1 << FORCED_PINS) - 1);

    a_r3_dir_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == AW'(ADDR_DIR)) |-> bus_rdata == '0);

    a_r7_low_modes_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < 3'd4) |-> pin_oe == '0);

    a_r10_no_pullup_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    a_r6_low_pins_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd4 || mode == 3'd5) && !sw_stby) |-> (pin_oe & FORCED_MASK) == FORCED_MASK);

    a_r12_two_edge_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == AW'(ADDR_PORT) && $past(rst_n) && $past(rst_n, 2))
        |-> bus_rdata == $past(pin_in, 2));

endmodule

bind gpio_addr_port gpio_addr_port_chk #(
    .W(W), .AW(AW), .FORCED_PINS(FORCED_PINS),
    .ADDR_DIR(ADDR_DIR), .ADDR_PORT(ADDR_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sw_stby(sw_stby),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_addr_port_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module gpio_addr_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_DIR = 16'hFEB9, A_DAT = 16'hFF69, A_PORT = 16'hFF59,
                            A_PU = 16'hFF70, A_OD = 16'hFF77;

    logic clk = 0;
    logic rst_n = 0, hw_stby = 0, man_rst = 0, sw_stby = 0, hold_en = 0;
    logic [2:0] mode = 3'd7;
    logic [7:0] addr_in = 0, bus_wdata = 0, pin_in = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [15:0] bus_addr = 0;
    logic [7:0] rd0, po0, oe0, pu0, rd1, po1, oe1, pu1;

    int total = 0, bad = 0, cycles = 0;
    bit started = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_addr_port u_gpio_addr_port (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .man_rst(man_rst), .mode(mode),
        .sw_stby(sw_stby), .hold_en(hold_en), .addr_in(addr_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
        .pin_in(pin_in), .pin_out(po0), .pin_oe(oe0), .pin_pu(pu0));

    gpio_addr_port #(.ROMLESS(1'b1)) u_gpio_addr_port_nr (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .man_rst(man_rst), .mode(mode),
        .sw_stby(sw_stby), .hold_en(hold_en), .addr_in(addr_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
        .pin_in(pin_in), .pin_out(po1), .pin_oe(oe1), .pin_pu(pu1));

    // Reference model state
    logic [7:0] m_dir = 0, m_dat = 0, m_pu = 0, m_od = 0, m_hold = 0;
    logic [7:0] hist[$] = '{8'h00, 8'h00};

    always @(posedge clk) begin
        cycles++;
        if (!rst_n || hw_stby) begin
            m_dir = 0; m_dat = 0; m_pu = 0; m_od = 0;
        end else if (man_rst) begin
            m_dat = 0; m_pu = 0; m_od = 0;
        end else if (bus_sel && bus_wr) begin
            if (bus_addr == A_DIR) m_dir = bus_wdata;
            if (bus_addr == A_DAT) m_dat = bus_wdata;
            if (bus_addr == A_PU)  m_pu  = bus_wdata;
            if (bus_addr == A_OD)  m_od  = bus_wdata;
        end
        if (!rst_n) begin
            hist = '{8'h00, 8'h00};
            m_hold = 0;
        end else begin
            hist.push_back(pin_in);
            void'(hist.pop_front());
            if (!sw_stby) m_hold = addr_in;
        end
    end

    // Expected pad signals for one variant (rl = ROMless)
    function automatic void model_pins(input bit rl, output logic [7:0] o, oe, pu);
        for (int i = 0; i < 8; i++) begin
            int role; // 0 input, 1 general output, 2 address
            bit pub = rl ? 1'b0 : m_pu[i];
            bit odb = rl ? 1'b0 : m_od[i];
            role = 0;
            if (mode == 7 && m_dir[i]) role = 1;
            if (mode == 6 && m_dir[i]) role = 2;
            if ((mode == 4 || mode == 5) && (i <= 4 || m_dir[i])) role = 2;
            o[i] = 0; oe[i] = 0; pu[i] = 0;
            if (role == 0) pu[i] = pub;
            else if (role == 1) begin
                if (odb) oe[i] = !m_dat[i];
                else begin o[i] = m_dat[i]; oe[i] = 1; end
            end else if (!(sw_stby && !hold_en)) begin
                oe[i] = 1;
                o[i] = sw_stby ? m_hold[i] : addr_in[i];
            end
        end
    endfunction

    function automatic logic [7:0] model_rd(input bit rl);
        if (!bus_sel || bus_wr) return 0;
        case (bus_addr)
            A_DAT:  return m_dat;
            A_PORT: return hist[0];
            A_PU:   return rl ? 8'h00 : m_pu;
            A_OD:   return rl ? 8'h00 : m_od;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        logic [7:0] eo, eoe, epu;
        #2;
        if (started) begin
            model_pins(1'b0, eo, eoe, epu);
            chk(phase, "pin_out", po0, eo);
            chk(phase, "pin_oe", oe0, eoe);
            chk(phase, "pin_pu", pu0, epu);
            chk(phase, "rdata", rd0, model_rd(1'b0));
            model_pins(1'b1, eo, eoe, epu);
            chk(phase, "nr pin_oe", oe1, eoe);
            chk(phase, "nr pin_pu", pu1, epu);
            chk(phase, "nr rdata", rd1, model_rd(1'b1));
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1; chk(tag, "read", rd0, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cycles > 20000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1; started = 1;
        #1;
        phase = "R1";
        chk("R1", "reset oe", oe0, 8'h00);
        chk("R1", "reset pu", pu0, 8'h00);
        rd_chk("R1", A_DAT, 8'h00);

        phase = "R3 R4 R14";
        wr(A_DIR, 8'hF0);
        wr(A_DAT, 8'hA5);
        wr(16'h1234, 8'hFF);
        rd_chk("R3", A_DIR, 8'h00);
        rd_chk("R4", A_DAT, 8'hA5);
        rd_chk("R14", 16'h1234, 8'h00);
        chk("R4", "oe mode7", oe0, 8'hF0);
        chk("R4", "out mode7", po0, 8'hA0);
        @(negedge clk); bus_sel = 0; #1;
        chk("R14", "idle rdata", rd0, 8'h00);

        phase = "R10 R13";
        wr(A_PU, 8'hFF);
        #1;
        chk("R10", "pu on inputs", pu0, 8'h0F);
        chk("R13", "nr pu", pu1, 8'h00);
        rd_chk("R13", A_PU, 8'hFF);
        #1; chk("R13", "nr pu read", rd1, 8'h00);

        phase = "R11 R13";
        wr(A_OD, 8'h30);
        #1;
        chk("R11", "od oe", oe0, 8'hD0);
        chk("R11", "od out", po0, 8'h80);
        chk("R13", "nr od oe", oe1, 8'hF0);

        phase = "R5";
        mode = 3'd6;
        foreach (addr_in[k]) begin
            @(negedge clk); addr_in = 8'h11 << (k % 4) ^ {k[2:0], 5'h5};
        end
        @(negedge clk); addr_in = 8'h3C; #1;
        chk("R5", "addr oe", oe0, 8'hF0);
        chk("R5", "addr out", po0, 8'h30);

        phase = "R6";
        wr(A_DIR, 8'h20);
        mode = 3'd4;
        @(negedge clk); addr_in = 8'hFF; #1;
        chk("R6", "mode4 oe", oe0, 8'h3F);
        chk("R6", "mode4 out", po0, 8'h3F);
        mode = 3'd5;
        @(negedge clk); addr_in = 8'h96; #1;
        chk("R6", "mode5 out", po0, 8'h16);

        phase = "R7";
        for (int m = 0; m < 4; m++) begin
            @(negedge clk); mode = 3'(m); #1;
            chk("R7", "low mode oe", oe0, 8'h00);
        end

        phase = "R8";
        wr(A_DIR, 8'hFF);
        mode = 3'd6; addr_in = 8'h5A; hold_en = 1;
        idle(2);
        sw_stby = 1;
        @(negedge clk); addr_in = 8'h33;
        idle(2); #1;
        chk("R8", "held addr", po0, 8'h5A);
        chk("R8", "held oe", oe0, 8'hFF);

        phase = "R9";
        hold_en = 0;
        idle(1); #1;
        chk("R9", "released oe", oe0, 8'h00);
        mode = 3'd7;
        wr(A_OD, 8'h00);
        wr(A_DAT, 8'h6C); #1;
        chk("R9", "gpo in stby", po0, 8'h6C);
        sw_stby = 0;

        phase = "R12";
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = A_PORT;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); pin_in = 8'(k * 37 + 5);
        end
        idle(3);
        #1; chk("R12", "settled readback", rd0, 8'(11 * 37 + 5));
        @(negedge clk); bus_sel = 0;

        phase = "R2";
        wr(A_DIR, 8'h0F);
        wr(A_PU, 8'hF0);
        wr(A_DAT, 8'hFF);
        @(negedge clk); man_rst = 1; bus_sel = 1; bus_wr = 1; bus_addr = A_DIR; bus_wdata = 8'h00;
        @(negedge clk); man_rst = 0; bus_sel = 0; bus_wr = 0; #1;
        chk("R2", "dir kept", oe0, 8'h0F);
        chk("R2", "data cleared", po0, 8'h00);
        chk("R2", "pu cleared", pu0, 8'h00);

        phase = "R1";
        @(negedge clk); hw_stby = 1;
        @(negedge clk); hw_stby = 0; #1;
        chk("R1", "hw stby oe", oe0, 8'h00);
        idle(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule